// File: doc/BRIEF.md
# Keypad Matrix Scanner with Debounce

This block watches a row/column key matrix of up to 8 rows and 11 columns and turns key activity into a stream of press and release events. Rows are inputs that read low when a closed switch joins them to a column driven low. Columns are outputs that the block drives low one at a time. While nothing is pressed, the scanner sits idle with every enabled column driven low and waits for an enabled row to fall.

Once woken, it repeats a scan, then reports, then waits. A scan releases every column and then drives each enabled column low alone. After a short settling delay it samples every row. The report pass compares the new image with the image from the previous scan and with the state already announced. An event is produced only when two consecutive scans agree and differ from what was last announced. This works the same way for presses and for releases. A row whose enabled columns all read pressed is treated as a row-to-ground switch and gets its own key number. The wait between scans is picked from four lengths, measured in prescaled ticks.

Top module: `keypad_scanner`

## Requirements
- R1: After reset no event is emitted and colLow equals colEn, so every enabled column is driven low. The scanner stays in this idle state until an enabled row reads low.
- R2: A scan first drives no column low. It then drives each enabled column low on its own, in ascending column order, and samples every row. Several keys held together are all detected. Events from one report pass come out in ascending ID order.
- R3: A press event is emitted only after the key reads pressed in two consecutive scans. A key seen pressed in a single scan produces no event.
- R4: A release event is emitted only after the key reads released in two consecutive scans. A key seen released in a single scan produces no event.
- R5: While any key is pressed, or is pending confirmation, the scanner keeps cycling through scan and wait. Once everything is released and announced, it returns to idle and starts no further scans.
- R6: A matrix key is reported with evtId = row*NUM_COLS + col + 1, which gives 1 to 88 by default. evtPressed is 1 for a press and 0 for a release. evtValid is a single-cycle strobe.
- R7: If every enabled column of an enabled row reads pressed, the block reports a row-to-ground key with evtId = NUM_ROWS*NUM_COLS + row + 1, which gives 89 to 96 by default. No ordinary key of that row is reported while this holds.
- R8: Only rows set in rowEn and columns set in colEn take part. A column outside colEn is never driven low, and a key on a disabled row or column neither wakes the scanner nor produces an event.
- R9: The wait between the end of a scan's report and the next scan is (waitSel+1)*WAIT_UNIT ticks. waitSel 0, 1, 2 and 3 select 1, 2, 3 and 4 units. One tick lasts TICK_DIV clock cycles.
- R10: Each column stays driven low across two tick boundaries before the rows are sampled. At a given clock this takes between TICK_DIV+1 and 2*TICK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowEn | input | NUM_ROWS | Rows that belong to the matrix |
| colEn | input | NUM_COLS | Columns that belong to the matrix |
| waitSel | input | 2 | Wait length between scans, in units of WAIT_UNIT ticks minus one |
| rowIn | input | NUM_ROWS | Row levels; low means connected to a low column or to ground |
| colLow | output | NUM_COLS | 1 drives that column low; 0 releases it |
| evtValid | output | 1 | One-cycle strobe marking a key event |
| evtId | output | 7 | Key number of the event |
| evtPressed | output | 1 | 1 for press, 0 for release |

## Verification
The bench goes after the edges of debounce. A press that lasts exactly one scan must be dropped, and a release that lasts exactly one scan while the key is held must be dropped too. A design that confirmed on the first scan would emit a spurious press, or a release/press pair. It also holds a whole row to ground together with a key on that row. Leaking the ordinary key, or reporting several column keys instead of the extension key, shows up as extra events. The bench restricts the matrix to a few pins and presses keys outside it, which catches columns driven outside colEn and wake-ups from disabled rows. It measures the idle gap between scans for two wait settings and the low time of each column, so a wait counter or settling counter that is off by a unit falls outside the expected window.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int KP_COL_W = 4;
  localparam int KP_ID_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_COL,
    ST_REPORT,
    ST_CHECK,
    ST_WAIT
  } scanState_e;

  // strobes from control to the event datapath
  typedef struct packed {
    logic                clearRaw;
    logic                sampleEn;
    logic [KP_COL_W-1:0] col;
    logic                reportEn;
    logic [KP_ID_W-1:0]  reportIdx;
  } scanStrb_t;
endpackage

// File: rtl/kp_scan_ctrl.sv
module kp_scan_ctrl
  import kp_pkg::*;
#(
  parameter int NUM_ROWS     = 8,
  parameter int NUM_COLS     = 11,
  parameter int TICK_DIV     = 1000,
  parameter int WAIT_UNIT    = 10,
  parameter int SETTLE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ROWS-1:0] rowEn,
  input  logic [NUM_COLS-1:0] colEn,
  input  logic [1:0]          waitSel,
  input  logic [NUM_ROWS-1:0] rowIn,
  input  logic                anyHeld,
  output logic [NUM_COLS-1:0] colLow,
  output scanStrb_t           strb
);
  localparam int TOTAL  = NUM_ROWS * NUM_COLS + NUM_ROWS;
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int WAIT_W = $clog2(4 * WAIT_UNIT + 1);
  localparam int SET_W  = $clog2(SETTLE_TICKS + 1);

  scanState_e          state;
  logic [TICK_W-1:0]   preCnt;
  logic                tick;
  logic [KP_COL_W-1:0] colIdx;
  logic [SET_W-1:0]    settleCnt;
  logic [WAIT_W-1:0]   waitCnt;
  logic [WAIT_W-1:0]   waitLimit;
  logic [KP_ID_W-1:0]  idx;
  logic                wake;
  logic                colActive;
  logic                lastCol;
  logic                sampleNow;

  assign tick      = (preCnt == TICK_W'(TICK_DIV - 1));
  assign wake      = |(rowEn & ~rowIn);
  assign colActive = colEn[colIdx];
  assign lastCol   = (colIdx == KP_COL_W'(NUM_COLS - 1));
  assign sampleNow = (state == ST_COL) && colActive && tick &&
                     (settleCnt == SET_W'(SETTLE_TICKS - 1));
  assign waitLimit = WAIT_W'((32'(waitSel) + 32'd1) * 32'(WAIT_UNIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + TICK_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      colIdx    <= '0;
      settleCnt <= '0;
      waitCnt   <= '0;
      idx       <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (wake) state <= ST_PRE;
        ST_PRE: begin
          if (tick) begin
            state     <= ST_COL;
            colIdx    <= '0;
            settleCnt <= '0;
          end
        end
        ST_COL: begin
          if (!colActive || sampleNow) begin
            settleCnt <= '0;
            if (lastCol) begin
              state <= ST_REPORT;
              idx   <= '0;
            end else begin
              colIdx <= colIdx + KP_COL_W'(1);
            end
          end else if (tick) begin
            settleCnt <= settleCnt + SET_W'(1);
          end
        end
        ST_REPORT: begin
          if (idx == KP_ID_W'(TOTAL - 1)) state <= ST_CHECK;
          else                            idx <= idx + KP_ID_W'(1);
        end
        ST_CHECK: begin
          if (anyHeld) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (waitCnt == waitLimit - WAIT_W'(1)) state <= ST_PRE;
            else                                   waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    colLow = '0;
    case (state)
      ST_COL:  if (colActive) colLow[colIdx] = 1'b1;
      ST_PRE:  colLow = '0;
      default: colLow = colEn;
    endcase
  end

  always_comb begin
    strb.clearRaw  = (state == ST_PRE);
    strb.sampleEn  = sampleNow;
    strb.col       = colIdx;
    strb.reportEn  = (state == ST_REPORT);
    strb.reportIdx = idx;
  end

  AST_WAIT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (waitCnt < waitLimit)); // R9
  AST_COL_ENTRY_FROM_PRE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(state == ST_COL)) |-> ($past(state) == ST_PRE && colIdx == '0)); // R2
endmodule

// File: rtl/kp_event_path.sv
module kp_event_path
  import kp_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_COLS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ROWS-1:0] rowEn,
  input  logic [NUM_COLS-1:0] colEn,
  input  logic [NUM_ROWS-1:0] rowIn,
  input  scanStrb_t           strb,
  output logic                anyHeld,
  output logic                evtValid,
  output logic [KP_ID_W-1:0]  evtId,
  output logic                evtPressed
);
  localparam int KEYS  = NUM_ROWS * NUM_COLS;
  localparam int TOTAL = KEYS + NUM_ROWS;

  logic [TOTAL-1:0] curImg;
  logic [TOTAL-1:0] prevImg;
  logic [TOTAL-1:0] stableImg;
  logic             curBit;
  logic             prevBit;
  logic             stableBit;

  for (genvar gr = 0; gr < NUM_ROWS; gr++) begin : g_row
    logic [NUM_COLS-1:0] rowBits;
    logic                rowFull;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              rowBits <= '0;
      else if (strb.clearRaw) rowBits <= '0;
      else if (strb.sampleEn) begin
        for (int c = 0; c < NUM_COLS; c++)
          if (strb.col == KP_COL_W'(c)) rowBits[c] <= rowEn[gr] & ~rowIn[gr];
      end
    end

    // whole row low on every enabled column: row-to-ground switch
    assign rowFull = rowEn[gr] && (|colEn) && (&(rowBits | ~colEn));
    assign curImg[gr*NUM_COLS +: NUM_COLS] = rowFull ? '0 : rowBits;
    assign curImg[KEYS + gr] = rowFull;
  end

  assign curBit    = curImg[strb.reportIdx];
  assign prevBit   = prevImg[strb.reportIdx];
  assign stableBit = stableImg[strb.reportIdx];
  assign anyHeld   = (|prevImg) || (|stableImg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevImg    <= '0;
      stableImg  <= '0;
      evtValid   <= 1'b0;
      evtId      <= '0;
      evtPressed <= 1'b0;
    end else begin
      evtValid <= 1'b0;
      if (strb.reportEn) begin
        prevImg[strb.reportIdx] <= curBit;
        if ((curBit == prevBit) && (curBit != stableBit)) begin
          stableImg[strb.reportIdx] <= curBit;
          evtValid   <= 1'b1;
          evtId      <= strb.reportIdx + KP_ID_W'(1);
          evtPressed <= curBit;
        end
      end
    end
  end

  AST_EVT_ID_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtId >= KP_ID_W'(1) && evtId <= KP_ID_W'(TOTAL))); // R6
  AST_EVT_FROM_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> $past(strb.reportEn)); // R6
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int NUM_ROWS     = 8,
  parameter int NUM_COLS     = 11,
  parameter int TICK_DIV     = 1000,
  parameter int WAIT_UNIT    = 10,
  parameter int SETTLE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_ROWS-1:0] rowEn,
  input  logic [NUM_COLS-1:0] colEn,
  input  logic [1:0]          waitSel,
  input  logic [NUM_ROWS-1:0] rowIn,
  output logic [NUM_COLS-1:0] colLow,
  output logic                evtValid,
  output logic [6:0]          evtId,
  output logic                evtPressed
);
  scanStrb_t strb;
  logic      anyHeld;

  kp_scan_ctrl #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .TICK_DIV(TICK_DIV),
    .WAIT_UNIT(WAIT_UNIT), .SETTLE_TICKS(SETTLE_TICKS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .rowEn(rowEn), .colEn(colEn), .waitSel(waitSel),
    .rowIn(rowIn), .anyHeld(anyHeld), .colLow(colLow), .strb(strb)
  );

  kp_event_path #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)
  ) i_path (
    .clk(clk), .rstN(rstN), .rowEn(rowEn), .colEn(colEn), .rowIn(rowIn),
    .strb(strb), .anyHeld(anyHeld), .evtValid(evtValid), .evtId(evtId),
    .evtPressed(evtPressed)
  );

  AST_COL_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (colLow & ~colEn) == '0); // R8
  AST_SAMPLE_ONE_COL: assert property (@(posedge clk) disable iff (!rstN)
    strb.sampleEn |-> ($onehot(colLow) && colLow[strb.col])); // R2
  AST_STRB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clearRaw, strb.sampleEn, strb.reportEn})); // R2
endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int NR   = 8;
  localparam int NC   = 11;
  localparam int TD   = 2;
  localparam int WU   = 3;
  localparam int KEYS = NR * NC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NR-1:0] rowEn = '1;
  logic [NC-1:0] colEn = '1;
  logic [1:0]    waitSel = 2'd0;
  logic [NR-1:0] rowIn;
  logic [NC-1:0] colLow;
  logic          evtValid;
  logic [6:0]    evtId;
  logic          evtPressed;

  logic [KEYS-1:0] keyDown = '0;
  logic [NR-1:0]   gndKey = '0;
  int checks = 0;
  int fails = 0;
  int evQ[$];
  int expQ[$];
  logic [NC-1:0] prevColLow = '0;
  int runLen = 0;
  int runsSeen = 0;
  bit done = 0;

  keypad_scanner #(
    .NUM_ROWS(NR), .NUM_COLS(NC), .TICK_DIV(TD), .WAIT_UNIT(WU), .SETTLE_TICKS(2)
  ) i_keypad_scanner (
    .clk(clk), .rstN(rstN), .rowEn(rowEn), .colEn(colEn), .waitSel(waitSel),
    .rowIn(rowIn), .colLow(colLow), .evtValid(evtValid), .evtId(evtId),
    .evtPressed(evtPressed)
  );

  always #10 clk = ~clk;

  // behavioural keypad: a row is low if grounded or joined to a low column
  always_comb begin
    for (int r = 0; r < NR; r++)
      rowIn[r] = ~(gndKey[r] | (|(keyDown[r*NC +: NC] & colLow)));
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock reference checks and event capture
  always @(negedge clk) begin
    if (rstN) begin
      if (evtValid) begin
        evQ.push_back(evtPressed ? 128 + int'(evtId) : int'(evtId));
        check(evtId >= 1 && evtId <= 96, "R6 id range", int'(evtId), 96);
      end
      check((colLow & ~colEn) == '0, "R8 column drive", int'(colLow), int'(colEn));
      if (colLow == prevColLow) runLen++;
      else begin
        if ($onehot(prevColLow) && prevColLow != colEn && runLen > 0) begin
          runsSeen++;
          check(runLen >= TD + 1 && runLen <= 2 * TD, "R10 settle", runLen, TD + 1);
        end
        runLen = 1;
        prevColLow = colLow;
      end
    end
  end

  task automatic waitScanStart();
    while (colLow == colEn) @(negedge clk);
  endtask

  task automatic waitScanEnd();
    while (colLow != colEn) @(negedge clk);
  endtask

  task automatic expectEvents(input string req, input int limit);
    int t = 0;
    while (evQ.size() < expQ.size() && t < limit) begin
      @(negedge clk);
      t++;
    end
    repeat (300) @(negedge clk);
    check(evQ.size() == expQ.size(), req, evQ.size(), expQ.size());
    for (int i = 0; i < expQ.size(); i++)
      if (i < evQ.size()) check(evQ[i] == expQ[i], req, evQ[i], expQ[i]);
    evQ.delete();
    expQ.delete();
  endtask

  task automatic countScans(input int n, output int cnt);
    logic wasIdle = (colLow == colEn);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wasIdle && colLow != colEn) cnt++;
      wasIdle = (colLow == colEn);
    end
  endtask

  task automatic measureGap(output int g);
    waitScanEnd();
    waitScanStart();
    waitScanEnd();
    g = 0;
    while (colLow == colEn) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic finishTest();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic setConfig(input logic [NR-1:0] re, input logic [NC-1:0] ce,
                           input logic [1:0] ws);
    @(posedge clk);
    #2;
    rowEn = re;
    colEn = ce;
    waitSel = ws;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishTest();
  end

  initial begin
    int n;
    int g;
    int bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(colLow == colEn, "R1 idle columns", int'(colLow), int'(colEn));
    check(!evtValid, "R1 no event", int'(evtValid), 0);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (colLow != colEn) bad++;
    end
    check(bad == 0 && evQ.size() == 0, "R1 stays idle", bad, 0);

    // R6: single key press and release, id 32 = row 2 col 9
    keyDown[31] = 1'b1;
    expQ.push_back(128 + 32);
    expectEvents("R6 press 32", 2000);
    countScans(300, n);
    check(n >= 2, "R5 rescans while held", n, 2);
    keyDown[31] = 1'b0;
    expQ.push_back(32);
    expectEvents("R4 release 32", 2000);
    countScans(200, n);
    check(n == 0, "R5 back to idle", n, 0);

    // R2: several keys, ascending order
    keyDown[0] = 1'b1;
    keyDown[16] = 1'b1;
    keyDown[87] = 1'b1;
    expQ.push_back(128 + 1);
    expQ.push_back(128 + 17);
    expQ.push_back(128 + 88);
    expectEvents("R2 multi press", 2000);
    keyDown[0] = 1'b0;
    keyDown[16] = 1'b0;
    keyDown[87] = 1'b0;
    expQ.push_back(1);
    expQ.push_back(17);
    expQ.push_back(88);
    expectEvents("R2 multi release", 2000);

    // R3: press seen in a single scan only
    @(negedge clk);
    keyDown[4] = 1'b1;
    waitScanStart();
    waitScanEnd();
    keyDown[4] = 1'b0;
    expectEvents("R3 one-scan press", 10);

    // R4: release seen in a single scan only
    keyDown[4] = 1'b1;
    expQ.push_back(128 + 5);
    expectEvents("R3 held press 5", 2000);
    waitScanEnd();
    waitScanStart();
    keyDown[4] = 1'b0;
    waitScanEnd();
    keyDown[4] = 1'b1;
    expectEvents("R4 one-scan release", 10);
    keyDown[4] = 1'b0;
    expQ.push_back(5);
    expectEvents("R4 release 5", 2000);

    // R7: row 3 to ground, with key 34 on the same row
    gndKey[3] = 1'b1;
    keyDown[33] = 1'b1;
    expQ.push_back(128 + 92);
    expectEvents("R7 ground press", 2000);
    gndKey[3] = 1'b0;
    keyDown[33] = 1'b0;
    expQ.push_back(92);
    expectEvents("R7 ground release", 2000);

    // R9: wait length for two settings
    keyDown[50] = 1'b1;
    expQ.push_back(128 + 51);
    expectEvents("R9 press 51", 2000);
    measureGap(g);
    check(g >= 97 + (WU - 1) * TD && g <= 98 + WU * TD, "R9 wait sel 0", g, 97 + WU * TD);
    keyDown[50] = 1'b0;
    expQ.push_back(51);
    expectEvents("R9 release 51", 2000);
    setConfig('1, '1, 2'd3);
    keyDown[50] = 1'b1;
    expQ.push_back(128 + 51);
    expectEvents("R9 press 51 sel 3", 2000);
    measureGap(g);
    check(g >= 97 + (4 * WU - 1) * TD && g <= 98 + 4 * WU * TD, "R9 wait sel 3", g,
          97 + 4 * WU * TD);
    keyDown[50] = 1'b0;
    expQ.push_back(51);
    expectEvents("R9 release 51 sel 3", 2000);

    // R8: rows 1..3 and columns 5..7 only
    setConfig(8'b0000_1110, 11'b000_1110_0000, 2'd0);
    keyDown[16] = 1'b1;
    keyDown[0] = 1'b1;
    keyDown[31] = 1'b1;
    expQ.push_back(128 + 17);
    expectEvents("R8 reduced press", 2000);
    keyDown[16] = 1'b0;
    keyDown[0] = 1'b0;
    keyDown[31] = 1'b0;
    expQ.push_back(17);
    expectEvents("R8 reduced release", 2000);
    keyDown[5] = 1'b1;
    countScans(200, n);
    check(n == 0 && evQ.size() == 0, "R8 disabled row no wake", n, 0);
    keyDown[5] = 1'b0;

    check(runsSeen > 0, "R10 columns observed", runsSeen, 1);
    finishTest();
  end
endmodule